// File: doc/BRIEF.md
# Dual-Channel Programmable Duty-Cycle Clock Divider

This block produces up to two divided clock outputs from one reference clock. Each channel takes one of two source-rate enables (`src0_tick` for the peripheral bus clock rate, `src1_tick` for the USB clock rate) and counts its ticks. A 4-bit divide value sets the period. A 4-bit compare value sets where in the period the output goes from low to high, so the duty cycle is programmable rather than fixed at half.

Software writes one 32-bit configuration word through a simple write port. Each channel reads its own 16-bit field of that word. A channel that is running takes new divide, compare and source settings only at the end of its current period, so the output never shows a shortened pulse. Clearing a channel's enable bit stops it at once: the output is forced low and the counter returns to zero.

Top module: `clkdiv_duo`

## Requirements
- R1: While enabled, each output period lasts exactly DIV+1 ticks of the selected source.
- R2: Every period starts with a low phase that lasts CMP+1 source ticks.
- R3: The high phase of each period lasts DIV−CMP source ticks.
- R4: When CMP is greater than or equal to DIV, the output stays low for as long as the channel is enabled.
- R5: Source-select bit 1 of a channel field picks `src0_tick` when 0 and `src1_tick` when 1.
- R6: Channel 0 uses bits 0 (enable), 1 (source select), 7:4 (DIV) and 11:8 (CMP). Channel 1 uses the same positions plus 16. Bits 2, 3 and 15:12 of each field are ignored.
- R7: Once a written enable bit of 0 is in the register, the output is low from the next reference cycle, and the counter is held at zero.
- R8: After a write sets the enable bit of a stopped channel, the output stays low for one reference cycle plus CMP+1 source ticks, then rises.
- R9: A write that changes DIV, CMP or source select on a running channel lets the current period finish with the old values. The new values apply from the next period.
- R10: After reset the configuration register is zero and both outputs are low.
- R11: The two channels run independently, each with its own settings and source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src0_tick | input | 1 | Tick enable at the peripheral bus clock rate |
| src1_tick | input | 1 | Tick enable at the USB clock rate |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word, one 16-bit field per channel |
| div_clk_o | output | NUM_CH | Divided clock outputs, one per channel |

## Verification
The assertions run on every cycle and check the following for each channel:
- A disabled channel drives its output low and its counter is at zero on the next cycle.
- The counter never passes the active divide value.
- The counter moves only on a selected tick.
- The active settings change only at a wrap or while the channel is idle.
- The output rises only as the counter steps just past the compare value.

The bench scenarios cover what no per-cycle check can show:
- the measured low and high lengths in reference cycles for each source;
- the one-cycle start-up after enable;
- a period that finishes on the old settings after a mid-period write;
- two channels running together with different settings.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int CNT_W     = 4;
  localparam int CH_STRIDE = 16;
  localparam int EN_BIT    = 0;
  localparam int SEL_BIT   = 1;
  localparam int DIV_LSB   = 4;
  localparam int CMP_LSB   = 8;

  typedef struct packed {
    logic             en;
    logic             sel;
    logic [CNT_W-1:0] div;
    logic [CNT_W-1:0] cmp;
  } chan_cfg_t;

  // Pull one channel's settings out of its slice of the configuration word.
  function automatic chan_cfg_t unpack_cfg(input logic [CH_STRIDE-1:0] f);
    chan_cfg_t c;
    c.en  = f[EN_BIT];
    c.sel = f[SEL_BIT];
    c.div = f[DIV_LSB +: CNT_W];
    c.cmp = f[CMP_LSB +: CNT_W];
    return c;
  endfunction

  // The period ends on the tick where the count equals the divide value.
  function automatic logic at_period_end(input logic [CNT_W-1:0] cnt,
                                         input logic [CNT_W-1:0] div);
    return cnt == div;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cnt,
                                                  input logic [CNT_W-1:0] div);
    return at_period_end(cnt, div) ? '0 : cnt + 1'b1;
  endfunction

  // The output is low for counts 0..cmp and high above cmp.
  function automatic logic phase_high(input logic [CNT_W-1:0] cnt,
                                      input logic [CNT_W-1:0] cmp);
    return cnt > cmp;
  endfunction

  function automatic int low_ticks(input int div, input int cmp);
    return (cmp >= div) ? div + 1 : cmp + 1;
  endfunction

  function automatic int high_ticks(input int div, input int cmp);
    return (cmp >= div) ? 0 : div - cmp;
  endfunction

endpackage

// File: rtl/clkdiv_cfg_reg.sv
module clkdiv_cfg_reg
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [31:0]             wr_data,
  output chan_cfg_t [NUM_CH-1:0]  cfg_o
);

  chan_cfg_t [NUM_CH-1:0] cfg_q;
  logic                   unused_wr_bits;

  // Only the meaningful fields are stored; the remaining bits are dropped.
  assign unused_wr_bits = ^wr_data;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[c] <= '0;
      end else if (wr_en) begin
        cfg_q[c] <= unpack_cfg(wr_data[c*CH_STRIDE +: CH_STRIDE]);
      end
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/clkdiv_src_sel.sv
module clkdiv_src_sel (
  input  logic sel_i,
  input  logic src0_tick_i,
  input  logic src1_tick_i,
  output logic tick_o
);

  always_comb begin
    tick_o = sel_i ? src1_tick_i : src0_tick_i;
  end

endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg_i,
  input  logic             src0_tick_i,
  input  logic             src1_tick_i,
  output logic             clk_o,
  output logic             tick_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o,
  output chan_cfg_t        act_o
);

  chan_cfg_t        act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic             running;
  logic             wrap;
  logic             load_act;

  // The source is taken from the active settings, so it only switches at a period end.
  clkdiv_src_sel u_sel (
    .sel_i       (act_q.sel),
    .src0_tick_i (src0_tick_i),
    .src1_tick_i (src1_tick_i),
    .tick_o      (tick)
  );

  assign running  = act_q.en && cfg_i.en;
  assign wrap     = running && tick && at_period_end(cnt_q, act_q.div);
  assign load_act = !act_q.en || !cfg_i.en || wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load_act) begin
        act_q <= cfg_i;
      end
      if (!running) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= next_count(cnt_q, act_q.div);
      end
    end
  end

  assign clk_o  = running && phase_high(cnt_q, act_q.cmp);
  assign tick_o = tick;
  assign wrap_o = wrap;
  assign cnt_o  = cnt_q;
  assign act_o  = act_q;

endmodule

// File: rtl/clkdiv_duo.sv
module clkdiv_duo
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src0_tick,
  input  logic              src1_tick,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [NUM_CH-1:0] div_clk_o
);

  chan_cfg_t [NUM_CH-1:0] cfg;
  chan_cfg_t [NUM_CH-1:0] act;

  // Internal events brought out for the checker.
  logic [NUM_CH-1:0]            ch_reg_en;
  logic [NUM_CH-1:0]            ch_act_en;
  logic [NUM_CH-1:0]            ch_tick;
  logic [NUM_CH-1:0]            ch_wrap;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_act_div;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_act_cmp;
  logic                         unused_act_sel;

  clkdiv_cfg_reg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cfg_o   (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    clkdiv_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_i       (cfg[c]),
      .src0_tick_i (src0_tick),
      .src1_tick_i (src1_tick),
      .clk_o       (div_clk_o[c]),
      .tick_o      (ch_tick[c]),
      .wrap_o      (ch_wrap[c]),
      .cnt_o       (ch_cnt[c]),
      .act_o       (act[c])
    );
    assign ch_reg_en[c]  = cfg[c].en;
    assign ch_act_en[c]  = act[c].en;
    assign ch_act_div[c] = act[c].div;
    assign ch_act_cmp[c] = act[c].cmp;
  end

  always_comb begin
    unused_act_sel = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      unused_act_sel = unused_act_sel ^ act[c].sel;
    end
  end

endmodule

// File: rtl/clkdiv_duo_chk.sv
module clkdiv_duo_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            reg_en,
  input logic [NUM_CH-1:0]            act_en,
  input logic [NUM_CH-1:0]            tick,
  input logic [NUM_CH-1:0]            wrap,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] act_div,
  input logic [NUM_CH-1:0][CNT_W-1:0] act_cmp,
  input logic [NUM_CH-1:0]            clk_out
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_en[c] |-> !clk_out[c]);

    assert_off_cnt_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_en[c] |=> (cnt[c] == '0));

    assert_cnt_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[c] <= act_div[c]);

    assert_cnt_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_en[c] && reg_en[c] && !tick[c]) |=> $stable(cnt[c]));

    assert_cfg_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (act_en[c] && reg_en[c] && !wrap[c]) |=>
        ($stable(act_div[c]) && $stable(act_cmp[c])));

    assert_rise_after_cmp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out[c]) |->
        ({1'b0, cnt[c]} == ({1'b0, act_cmp[c]} + 5'd1)));
  end

endmodule

bind clkdiv_duo clkdiv_duo_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_en  (ch_reg_en),
  .act_en  (ch_act_en),
  .tick    (ch_tick),
  .wrap    (ch_wrap),
  .cnt     (ch_cnt),
  .act_div (ch_act_div),
  .act_cmp (ch_act_cmp),
  .clk_out (div_clk_o)
);

// File: tb/clkdiv_duo_tb_top.sv
module clkdiv_duo_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src0_tick = 1'b1;
  logic        src1_tick;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  div_clk;
  int          ph = 0;
  int          n_run = 0;
  int          n_fail = 0;

  // 125 MHz reference clock.
  always #4 clk = ~clk;

  // src1 ticks once every third reference cycle; src0 ticks every cycle.
  always @(negedge clk) ph <= (ph == 2) ? 0 : ph + 1;
  assign src1_tick = (ph == 0);

  clkdiv_duo #(.NUM_CH(2)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src0_tick (src0_tick),
    .src1_tick (src1_tick),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .div_clk_o (div_clk)
  );

  // Columns: sel, div, cmp, expected high cycles, expected low cycles.
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 4'd1,  4'd0,  8'd1,  8'd1},
    {1'b0, 4'd3,  4'd1,  8'd2,  8'd2},
    {1'b0, 4'd7,  4'd2,  8'd5,  8'd3},
    {1'b0, 4'd15, 4'd14, 8'd1,  8'd15},
    {1'b1, 4'd2,  4'd0,  8'd6,  8'd3},
    {1'b1, 4'd5,  4'd3,  8'd6,  8'd12},
    {1'b0, 4'd15, 4'd0,  8'd15, 8'd1},
    {1'b1, 4'd9,  4'd4,  8'd15, 8'd15}
  };

  function automatic logic [15:0] field(input logic en, input logic sel,
                                        input int div, input int cmp);
    logic [15:0] f;
    f = 16'hF00C;                  // ignored bits set on purpose (R6)
    f[0]    = en;
    f[1]    = sel;
    f[7:4]  = div[3:0];
    f[11:8] = cmp[3:0];
    return f;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic wait_rise(input int ch, output bit ok);
    logic prev;
    prev = div_clk[ch];
    ok   = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (div_clk[ch] && !prev) begin
        ok = 1'b1;
        break;
      end
      prev = div_clk[ch];
    end
  endtask

  // Called at a negedge where the output is high; counts high, then low cycles.
  task automatic measure(input int ch, input int h0, output int h, output int l);
    h = h0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (div_clk[ch]) h++;
      else break;
    end
    l = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!div_clk[ch]) l++;
      else break;
    end
  endtask

  task automatic count_high(input int ch, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (div_clk[ch]) n++;
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int h;
    int l;
    int n;
    bit ok;

    // R10: reset state.
    repeat (3) @(negedge clk);
    check("R10 out during reset", int'(div_clk), 0);
    rst_n = 1'b1;
    count_high(0, 30, n);
    check("R10 ch0 idle after reset", n, 0);
    count_high(1, 5, n);
    check("R10 ch1 idle after reset", n, 0);

    // Table of settings on channel 0 (R1, R2, R3, R5, R6).
    for (int v = 0; v < 8; v++) begin
      write_cfg(32'h0);
      write_cfg({16'h0, field(1'b1, VEC[v][24], int'(VEC[v][23:20]), int'(VEC[v][19:16]))});
      wait_rise(0, ok);
      check("R1/R5 rise seen", int'(ok), 1);
      measure(0, 1, h, l);
      check($sformatf("R3/R5/R6 high vec%0d", v), h, int'(VEC[v][15:8]));
      check($sformatf("R2/R5/R6 low vec%0d", v), l, int'(VEC[v][7:0]));
    end

    // R7: disable while high forces the output low at once.
    write_cfg(32'h0);
    write_cfg({16'h0, field(1'b1, 1'b0, 7, 2)});
    wait_rise(0, ok);
    write_cfg(32'h0);
    check("R7 low right after disable", int'(div_clk[0]), 0);
    count_high(0, 40, n);
    check("R7 stays low while disabled", n, 0);

    // R8: enable from stopped; low for one cycle plus CMP+1 ticks.
    write_cfg({16'h0, field(1'b1, 1'b0, 5, 2)});
    l = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!div_clk[0]) l++;
      else break;
    end
    check("R8 first low after enable", l, 4);

    // R4: compare not below divide keeps the output low.
    write_cfg(32'h0);
    write_cfg({16'h0, field(1'b1, 1'b0, 4, 4)});
    count_high(0, 60, n);
    check("R4 cmp equal div", n, 0);
    write_cfg(32'h0);
    write_cfg({16'h0, field(1'b1, 1'b0, 2, 9)});
    count_high(0, 60, n);
    check("R4 cmp above div", n, 0);

    // R9: a mid-period write lets the running period finish on old values.
    write_cfg(32'h0);
    write_cfg({16'h0, field(1'b1, 1'b0, 7, 3)});
    wait_rise(0, ok);
    cfg_we    = 1'b1;
    cfg_wdata = {16'h0, field(1'b1, 1'b0, 3, 1)};
    @(negedge clk);
    cfg_we    = 1'b0;
    measure(0, 2, h, l);
    check("R9 old high completes", h, 4);
    check("R9 new low applies", l, 2);
    measure(0, 1, h, l);
    check("R9 new high", h, 2);
    check("R9 new low again", l, 2);

    // R11: both channels at once with different settings and sources.
    write_cfg(32'h0);
    write_cfg({field(1'b1, 1'b1, 4, 1), field(1'b1, 1'b0, 3, 1)});
    wait_rise(1, ok);
    measure(1, 1, h, l);
    check("R11/R6 ch1 high", h, 9);
    check("R11/R6 ch1 low", l, 6);
    wait_rise(0, ok);
    measure(0, 1, h, l);
    check("R11 ch0 high", h, 2);
    check("R11 ch0 low", l, 2);
    write_cfg({16'h0, field(1'b1, 1'b0, 3, 1)});
    count_high(1, 30, n);
    check("R11/R7 ch1 off ch0 on", n, 0);

    summary();
    $finish;
  end

endmodule